// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block turns a 48 MHz reference clock into a one-cycle enable pulse, `os_tick`. The pulse comes at sixteen times the UART bit rate, and UART shift logic uses it as its oversampling enable. The pulse rate is set by a divisor made of two parts:

- a 14-bit integer part `n`;
- a 3-bit fraction `f` that adds f/8 of a reference cycle to the divisor.

The generator cannot split a reference cycle. It therefore realises the fraction by making some division periods one reference cycle longer than the others. Over eight periods the average comes to exactly n + f/8 reference cycles.

Two integer codes select fixed fast rates:

- `n = 0` gives a tick on every reference cycle, which is 3 Mbaud.
- `n = 1` gives an average of 1.5 cycles per tick, which is 2 Mbaud.

For both codes the programmed fraction is ignored.

A new divisor is presented on `div_int`/`div_frac` together with a one-cycle `div_load` strobe. The generator holds the new value and switches to it only at a period boundary, so it never produces a shortened period. The block has no data stream, so it has no valid/ready handshake. All of its pins are plain control pins.

Top module: `baud_frac_gen`

## Requirements
- R1: While `rst_n` is low, `os_tick` is 0. The reset divisor is `RST_DIV` (default 26) with a zero fraction. The first tick comes `RST_DIV`-1 clock edges after the first edge at which `rst_n` is high.
- R2: With an integer code n in 2..16383 and a zero fraction, ticks are exactly n cycles apart. Each tick is high for one cycle.
- R3: A 3-bit accumulator starts at 0 whenever a setting is applied. At every boundary the effective fraction is added to it. When that addition overflows past 7, the period that follows is n+1 cycles long; otherwise it is n cycles. This makes any 8 periods from the start total 8n+f.
- R4: Integer code 0 gives a period of 1 cycle (a tick on every cycle), whatever value `div_frac` holds.
- R5: Integer code 1 ignores `div_frac` and behaves as n=1 with a fraction of 4/8. After the setting is applied, the periods alternate 1, 2, 1, 2 and so on.
- R6: A `div_load` pulse takes effect at the first tick at or after the cycle in which it is sampled. The period already running completes with its old length.
- R7: If more than one load arrives before a boundary, the last one is the one applied.
- R8: Loading a setting restarts the accumulator at 0, even when the setting is the same as the one in use.
- R9: Between loads, the fraction pattern continues across periods without interruption, because the accumulator keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_load | input | 1 | One-cycle strobe that captures `div_int`/`div_frac` |
| div_int | input | INT_W (14) | Integer part of the divisor; codes 0 and 1 are the special fast rates |
| div_frac | input | FRAC_W (3) | Fraction of the divisor, in eighths |
| os_tick | output | 1 | One-cycle enable at the x16 oversampling rate |

## Verification
The bench measures the spacing of every tick and compares it with a model of the period-length rule. It covers several cases, each chosen to expose a specific fault:

- **Fraction timing.** A design that adds the fraction at the wrong moment, or never resets the accumulator, lengthens the wrong periods.
- **Fraction codes 1 through 7.** These are tried together with the special integer codes 0 and 1. A design that honoured `div_frac` for those codes would give irregular spacing at full rate, or a 1.5-cycle pattern that is out of phase.
- **Loads in the middle of a long period.** These check for a cut-short period and for an overwritten pending load.
- **Largest divisor with a fraction.** Run at 16383 plus 1/8, this checks the counter width.

// File: rtl/bfg_pkg.sv
package bfg_pkg;
  localparam int unsigned BFG_INT_W  = 14;
  localparam int unsigned BFG_FRAC_W = 3;

  typedef enum logic [1:0] {
    RATE_FULL,      // one tick per reference cycle
    RATE_THREE_HALF,// ticks every 1.5 reference cycles on average
    RATE_DIVIDED    // general integer plus fraction
  } bfg_rate_e;

  function automatic bfg_rate_e bfg_classify(input int unsigned code);
    if (code == 0)      return RATE_FULL;
    else if (code == 1) return RATE_THREE_HALF;
    else                return RATE_DIVIDED;
  endfunction
endpackage

// File: rtl/bfg_setting_sel.sv
module bfg_setting_sel
  import bfg_pkg::*;
#(
  parameter int unsigned INT_W   = BFG_INT_W,
  parameter int unsigned FRAC_W  = BFG_FRAC_W,
  parameter int unsigned RST_DIV = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [INT_W-1:0]  n_i,
  input  logic [FRAC_W-1:0] f_i,
  input  logic              bnd_i,
  output logic [INT_W-1:0]  n_eff_o,
  output logic [FRAC_W-1:0] f_eff_o,
  output logic              restart_o
);
  localparam logic [FRAC_W-1:0] HALF_FRAC = {1'b1, {(FRAC_W-1){1'b0}}};

  logic [INT_W-1:0]  act_n, pend_n, sel_n;
  logic [FRAC_W-1:0] act_f, pend_f, sel_f;
  logic              pend_v;
  bfg_rate_e         rate;

  // The newest request wins: a strobe in this cycle beats an older pending one.
  always_comb begin
    if (load_i) begin
      sel_n = n_i;
      sel_f = f_i;
    end else if (pend_v) begin
      sel_n = pend_n;
      sel_f = pend_f;
    end else begin
      sel_n = act_n;
      sel_f = act_f;
    end
  end

  assign rate      = bfg_classify(int'(sel_n));
  assign restart_o = bnd_i & (load_i | pend_v);

  always_comb begin
    unique case (rate)
      RATE_FULL: begin
        n_eff_o = INT_W'(1);
        f_eff_o = '0;
      end
      RATE_THREE_HALF: begin
        n_eff_o = INT_W'(1);
        f_eff_o = HALF_FRAC;
      end
      default: begin
        n_eff_o = sel_n;
        f_eff_o = sel_f;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_n  <= INT_W'(RST_DIV);
      act_f  <= '0;
      pend_n <= '0;
      pend_f <= '0;
      pend_v <= 1'b0;
    end else if (bnd_i) begin
      act_n  <= sel_n;
      act_f  <= sel_f;
      pend_v <= 1'b0;
    end else if (load_i) begin
      pend_n <= n_i;
      pend_f <= f_i;
      pend_v <= 1'b1;
    end
  end

  // R6: a boundary always consumes what is pending
  a_r6_pend_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    bnd_i |=> !pend_v);
  // R7: a strobe away from a boundary is held until the next one
  a_r7_load_held: assert property (@(posedge clk) disable iff (!rst_n)
    load_i && !bnd_i |=> pend_v && pend_n == $past(n_i) && pend_f == $past(f_i));
endmodule

// File: rtl/bfg_frac_accum.sv
module bfg_frac_accum #(
  parameter int unsigned FRAC_W = bfg_pkg::BFG_FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bnd_i,
  input  logic              restart_i,
  input  logic [FRAC_W-1:0] f_i,
  output logic              carry_o
);
  logic [FRAC_W-1:0] acc, base;
  logic [FRAC_W:0]   sum;

  assign base    = restart_i ? '0 : acc;
  assign sum     = {1'b0, base} + {1'b0, f_i};
  assign carry_o = sum[FRAC_W];

  always_ff @(posedge clk) begin
    if (!rst_n)     acc <= '0;
    else if (bnd_i) acc <= sum[FRAC_W-1:0];
  end

  // R9: the accumulator only moves at period boundaries
  a_r9_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bnd_i |=> $stable(acc));
  // R3: a zero fraction never stretches a period
  a_r3_zero_frac_no_stretch: assert property (@(posedge clk) disable iff (!rst_n)
    bnd_i && f_i == '0 |-> !carry_o);
  // R8: after a restart the accumulator holds exactly the applied fraction
  a_r8_restart_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bnd_i && restart_i |=> acc == $past(f_i));
endmodule

// File: rtl/bfg_period_counter.sv
module bfg_period_counter #(
  parameter int unsigned INT_W   = bfg_pkg::BFG_INT_W,
  parameter int unsigned RST_DIV = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INT_W-1:0] base_i,
  input  logic             carry_i,
  output logic             tick_o
);
  logic [INT_W-1:0] cnt, len_m1;

  // Next period length minus one; wraps cleanly at the top code.
  assign len_m1 = base_i + INT_W'(carry_i) - INT_W'(1);
  assign tick_o = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= INT_W'(RST_DIV - 1);
    else if (tick_o) cnt <= len_m1;
    else             cnt <= cnt - INT_W'(1);
  end

  // R2: a tick is one cycle wide unless the next period is a single cycle
  a_r2_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o && len_m1 != '0 |=> !tick_o);
  // R6: inside a period the count only steps down, no load can cut it short
  a_r6_no_runt: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_o |=> cnt == $past(cnt) - INT_W'(1));
  // R1: the reset state is not a boundary
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!rst_n || cnt == INT_W'(RST_DIV - 1)));
endmodule

// File: rtl/baud_frac_gen.sv
module baud_frac_gen #(
  parameter int unsigned INT_W   = bfg_pkg::BFG_INT_W,
  parameter int unsigned FRAC_W  = bfg_pkg::BFG_FRAC_W,
  parameter int unsigned RST_DIV = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              div_load,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              os_tick
);
  logic [INT_W-1:0]  nx_n;
  logic [FRAC_W-1:0] nx_f;
  logic              restart, carry;

  bfg_setting_sel #(.INT_W(INT_W), .FRAC_W(FRAC_W), .RST_DIV(RST_DIV)) u_sel (
    .clk(clk), .rst_n(rst_n), .load_i(div_load), .n_i(div_int), .f_i(div_frac),
    .bnd_i(os_tick), .n_eff_o(nx_n), .f_eff_o(nx_f), .restart_o(restart)
  );

  bfg_frac_accum #(.FRAC_W(FRAC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .bnd_i(os_tick), .restart_i(restart),
    .f_i(nx_f), .carry_o(carry)
  );

  bfg_period_counter #(.INT_W(INT_W), .RST_DIV(RST_DIV)) u_cnt (
    .clk(clk), .rst_n(rst_n), .base_i(nx_n), .carry_i(carry), .tick_o(os_tick)
  );

  // R4: a boundary that applies integer code 0 is followed by another tick
  a_r4_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
    os_tick && div_load && div_int == '0 |=> os_tick);
  // R5: a boundary that applies integer code 1 gives a one-cycle first period
  a_r5_first_short: assert property (@(posedge clk) disable iff (!rst_n)
    os_tick && div_load && div_int == INT_W'(1) |=> os_tick);
endmodule

// File: tb/baud_frac_gen_test.sv
module baud_frac_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int INT_W = 14;
  localparam int FRAC_W = 3;
  localparam int RST_DIV = 26;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic div_load = 1'b0;
  logic [INT_W-1:0] div_int = '0;
  logic [FRAC_W-1:0] div_frac = '0;
  logic os_tick;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  string req = "R1";

  // bench model of the requirements
  int m_act_n, m_act_f, m_pend_n, m_pend_f, m_acc, exp_len, since;
  bit m_pend_v, have_exp;

  baud_frac_gen #(.INT_W(INT_W), .FRAC_W(FRAC_W), .RST_DIV(RST_DIV)) uut (
    .clk(clk), .rst_n(rst_n), .div_load(div_load), .div_int(div_int),
    .div_frac(div_frac), .os_tick(os_tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int eff_n(input int n);
    return (n < 2) ? 1 : n;
  endfunction

  function automatic int eff_f(input int n, input int f);
    if (n == 0) return 0;
    if (n == 1) return 4;
    return f;
  endfunction

  task automatic check(input bit ok, input int act, input int expv, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // one reference cycle; optional load in this cycle
  task automatic step(input bit ld, input int n, input int f);
    int sel_n, sel_f, base, sum;
    bit rs;
    @(negedge clk);
    div_load = ld;
    if (ld) begin
      div_int  = INT_W'(n);
      div_frac = FRAC_W'(f);
    end
    #1;
    since++;
    if (os_tick) begin
      if (have_exp) check(since == exp_len, since, exp_len, "tick spacing");
      rs = 1'b1;
      if (ld) begin sel_n = n; sel_f = f; end
      else if (m_pend_v) begin sel_n = m_pend_n; sel_f = m_pend_f; end
      else begin sel_n = m_act_n; sel_f = m_act_f; rs = 1'b0; end
      base = rs ? 0 : m_acc;
      sum = base + eff_f(sel_n, sel_f);
      m_acc = sum % 8;
      exp_len = eff_n(sel_n) + (sum >= 8 ? 1 : 0);
      m_act_n = sel_n; m_act_f = sel_f; m_pend_v = 1'b0;
      since = 0; have_exp = 1'b1;
    end else if (ld) begin
      m_pend_n = n; m_pend_f = f; m_pend_v = 1'b1;
    end
  endtask

  task automatic run(input int cycles);
    for (int i = 0; i < cycles; i++) step(1'b0, 0, 0);
  endtask

  task automatic load_and_run(input int n, input int f, input int cycles);
    step(1'b1, n, f);
    run(cycles);
  endtask

  initial begin
    m_act_n = RST_DIV; m_act_f = 0; m_acc = 0; m_pend_v = 1'b0;
    m_pend_n = 0; m_pend_f = 0;
    // R1: quiet during reset
    req = "R1";
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      check(os_tick == 1'b0, os_tick, 0, "tick in reset");
    end
    @(negedge clk);
    rst_n = 1'b1;
    since = 0; exp_len = RST_DIV - 1; have_exp = 1'b1;
    run(RST_DIV + 2);
    // R2: reset divisor and a plain integer divisor
    req = "R2";
    run(3 * RST_DIV);
    load_and_run(5, 0, 60);
    // R3: fractional patterns
    req = "R3";
    load_and_run(7, 3, 160);
    load_and_run(2, 7, 80);
    load_and_run(3, 1, 80);
    // R4: full rate ignores the fraction
    req = "R4";
    load_and_run(0, 5, 30);
    // R5: code 1 alternates 1,2 and ignores the fraction
    req = "R5";
    load_and_run(1, 3, 30);
    // R6: load in the middle of a long period, no runt
    req = "R6";
    load_and_run(300, 0, 450);
    load_and_run(4, 2, 700);
    // R7: the last of several loads wins
    req = "R7";
    load_and_run(200, 0, 250);
    step(1'b1, 9, 0);
    step(1'b1, 6, 5);
    run(300);
    // R8: reloading the same value restarts the accumulator
    req = "R8";
    run(17);
    load_and_run(6, 5, 120);
    // R9: long random run with the pattern carried across periods
    req = "R9";
    void'($urandom(32'd12345));
    for (int k = 0; k < 25; k++) begin
      load_and_run(2 + int'($urandom % 40), int'($urandom % 8), 50 + int'($urandom % 200));
    end
    // R2: largest divisor with a fraction (counter width)
    req = "R2";
    load_and_run(16383, 1, 2 * 16384 + 20);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule